// File: doc/BRIEF.md
# Soft-Decision Viterbi Path-Metric and Traceback Core

This block is the arithmetic heart of a fixed-code Viterbi decoder for a rate-1/2 convolutional code of constraint length 7. Each accepted symbol carries two 3-bit soft values, one per code output. From these the block forms four branch distances. A bank of add-compare-select units, one for each of the 64 trellis states, extends the path metrics. Each unit keeps the smaller candidate and writes one survivor decision bit per state into a survivor store. The smallest metric and the index of the state that holds it are registered with every update. The next update subtracts that minimum, which keeps all metrics inside 8 bits.

Once the survivor store is full, every accepted symbol starts a traceback from the lowest-metric state. The walk goes back through all stored columns and yields one decoded bit, one clock after the symbol. The latency is fixed. After reset, state 0 starts with metric 0 and every other state starts with a parameterised penalty, so the decoder favours an encoder that starts from all zeros. Depuncturing and node synchronisation belong to neighbouring blocks.

Top module: `vit_decoder_core`

## Requirements
- R1: After reset `out_valid` stays low until L+1 symbols have been accepted, with L = TB_DEPTH + K - 2 (40 by default). The first pulse appears in the clock cycle after the edge that accepts symbol number L (counting from 0).
- R2: From then on, every accepted symbol produces exactly one `out_valid` pulse, one cycle wide, one clock after the edge that accepted the symbol. No pulse appears without an accepted symbol.
- R3: The encoder model is as follows. The newest source bit u and the six previous bits form the window {u, s5..s0}, with s5 the most recent. `in_soft_a` carries the parity of the window ANDed with 171 octal. `in_soft_b` carries the parity of the window ANDed with 133 octal. The most significant generator bit taps u. Soft values are offset binary: 0 is a confident zero and 7 is a confident one. The encoder starts from the all-zero state. With error-free soft values, the k-th `out_bit` equals the k-th source bit.
- R4: A single soft value fully or mostly inverted, with no more than one such error per 30 symbols, is corrected. The decoded stream still equals the source.
- R5: While `in_valid` is low, the soft inputs have no effect on metrics, survivors or output. Random values during such cycles leave the decoded stream unchanged.
- R6: Symbols presented on consecutive cycles decode the same way as symbols separated by idle cycles.
- R7: No path metric ever overflows its 8-bit width. A stream of 4000 symbols with periodic errors decodes correctly.
- R8: The traceback starts from the state that holds the lowest path metric, taking the lowest index on a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Soft symbol pair present this cycle |
| in_soft_a | input | SOFT_W | Soft value for the first code output (171 octal) |
| in_soft_b | input | SOFT_W | Soft value for the second code output (133 octal) |
| out_valid | output | 1 | Decoded bit present this cycle |
| out_bit | output | 1 | Decoded source bit, in source order |

## Verification
When symbols arrive back-to-back, the traceback for symbol t reads the survivor store and the best-state register on the same edge where symbol t+1 shifts a new column in and renormalises the metrics. A wrong sampling order would trace from the wrong start state or through a shifted column. The table cases with zero idle cycles provoke this collision. Cases with idle gaps serve as the reference: each decoded stream is compared bit by bit with the source bits, and both kinds of case must match the source.

// File: rtl/vit_pkg.sv
package vit_pkg;

   // Parity of the bits of v (constant function, used at elaboration).
   function automatic int unsigned vit_parity(input int unsigned v);
      int unsigned p;
      p = 0;
      for (int b = 0; b < 32; b++) p = p ^ ((v >> b) & 1);
      return p;
   endfunction

   // Index of the branch distance for an expected code pair.
   function automatic int unsigned vit_pair_index(input int unsigned ca, input int unsigned cb);
      return (ca << 1) | cb;
   endfunction

   localparam int unsigned VIT_PAIRS = 4;

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
   parameter int SOFT_W = 3,
   parameter int BM_W   = SOFT_W + 1
) (
   input  logic [SOFT_W-1:0] soft_a,
   input  logic [SOFT_W-1:0] soft_b,
   output logic [BM_W-1:0]   bm [vit_pkg::VIT_PAIRS]
);
   localparam logic [SOFT_W-1:0] SOFT_MAX = '1;

   generate
      if (BM_W < SOFT_W + 1) begin : g_bad_bm
         $error("vit_bmu: BM_W too narrow for a sum of two distances");
      end
      for (genvar c = 0; c < int'(vit_pkg::VIT_PAIRS); c++) begin : g_pair
         localparam bit EXP_A = ((c >> 1) & 1) == 1;
         localparam bit EXP_B = (c & 1) == 1;
         logic [BM_W-1:0] dist_a, dist_b;
         if (EXP_A) begin : g_a1
            assign dist_a = BM_W'(SOFT_MAX - soft_a);
         end else begin : g_a0
            assign dist_a = BM_W'(soft_a);
         end
         if (EXP_B) begin : g_b1
            assign dist_b = BM_W'(SOFT_MAX - soft_b);
         end else begin : g_b0
            assign dist_b = BM_W'(soft_b);
         end
         assign bm[c] = dist_a + dist_b;
      end
   endgenerate
endmodule

// File: rtl/vit_acs.sv
module vit_acs #(
   parameter int PM_W = 8,
   parameter int BM_W = 4
) (
   input  logic [PM_W-1:0] pm_even,
   input  logic [PM_W-1:0] pm_odd,
   input  logic [BM_W-1:0] bm_even,
   input  logic [BM_W-1:0] bm_odd,
   output logic [PM_W:0]   sum_sel,
   output logic            pick_odd
);
   localparam int SW = PM_W + 1;
   logic [PM_W:0] cand_even, cand_odd;

   assign cand_even = {1'b0, pm_even} + SW'(bm_even);
   assign cand_odd  = {1'b0, pm_odd}  + SW'(bm_odd);
   // strict compare: equal candidates keep the even predecessor
   assign pick_odd  = cand_odd < cand_even;
   assign sum_sel   = pick_odd ? cand_odd : cand_even;
endmodule

// File: rtl/vit_pm_array.sv
module vit_pm_array #(
   parameter int          K          = 7,
   parameter int          PM_W       = 8,
   parameter int          BM_W       = 4,
   parameter int unsigned GEN_A      = 'o171,
   parameter int unsigned GEN_B      = 'o133,
   parameter int          START_BIAS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sym_valid,
   input  logic [BM_W-1:0] bm [vit_pkg::VIT_PAIRS],
   output logic [(1<<(K-1))-1:0] dec_col,
   output logic [K-2:0]    best_state
);
   localparam int NS    = 1 << (K - 1);
   localparam int SW    = K - 1;
   localparam int NODES = 2 * NS - 1;

   logic [PM_W-1:0] pm_q [NS];
   logic [PM_W:0]   sel_sum [NS];
   logic [PM_W:0]   norm_sum [NS];
   logic [PM_W-1:0] min_q;
   logic [SW-1:0]   best_q;
   logic [PM_W:0]   tr_val [NODES];
   logic [SW-1:0]   tr_idx [NODES];
   logic [PM_W:0]   min_next;

   generate
      if (START_BIAS < 0 || START_BIAS >= (1 << PM_W)) begin : g_bad_bias
         $error("vit_pm_array: START_BIAS outside the metric range");
      end
      for (genvar ns = 0; ns < NS; ns++) begin : g_state
         localparam int unsigned PE  = (ns << 1) & (NS - 1);
         localparam int unsigned PO  = PE | 1;
         localparam int unsigned U   = ns >> (K - 2);
         localparam int unsigned WE  = (U << (K - 1)) | PE;
         localparam int unsigned WO  = (U << (K - 1)) | PO;
         localparam int unsigned BIE = vit_pkg::vit_pair_index(vit_pkg::vit_parity(WE & GEN_A),
                                                              vit_pkg::vit_parity(WE & GEN_B));
         localparam int unsigned BIO = vit_pkg::vit_pair_index(vit_pkg::vit_parity(WO & GEN_A),
                                                              vit_pkg::vit_parity(WO & GEN_B));
         vit_acs #(.PM_W(PM_W), .BM_W(BM_W)) u_acs (
            .pm_even (pm_q[PE]),
            .pm_odd  (pm_q[PO]),
            .bm_even (bm[BIE]),
            .bm_odd  (bm[BIO]),
            .sum_sel (sel_sum[ns]),
            .pick_odd(dec_col[ns])
         );
         assign norm_sum[ns] = sel_sum[ns] - {1'b0, min_q};
         assign tr_val[NS - 1 + ns] = sel_sum[ns];
         assign tr_idx[NS - 1 + ns] = SW'(ns);

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            sym_valid |-> (sel_sum[ns] >= {1'b0, min_q}) && !norm_sum[ns][PM_W]); // R7
         AST_BEST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            pm_q[ns] >= pm_q[best_q]); // R8
      end

      // minimum tree, heap order; left child holds lower indices, wins ties
      for (genvar n = 0; n < NS - 1; n++) begin : g_min
         logic take_right;
         assign take_right = tr_val[2*n+2] < tr_val[2*n+1];
         assign tr_val[n]  = take_right ? tr_val[2*n+2] : tr_val[2*n+1];
         assign tr_idx[n]  = take_right ? tr_idx[2*n+2] : tr_idx[2*n+1];
      end
   endgenerate

   assign min_next = tr_val[0] - {1'b0, min_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : PM_W'(START_BIAS);
         min_q  <= '0;
         best_q <= '0;
      end else if (sym_valid) begin
         for (int i = 0; i < NS; i++) pm_q[i] <= norm_sum[i][PM_W-1:0];
         min_q  <= min_next[PM_W-1:0];
         best_q <= tr_idx[0];
      end
   end

   assign best_state = best_q;
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
   parameter int K        = 7,
   parameter int TB_DEPTH = 35
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sym_valid,
   input  logic [(1<<(K-1))-1:0] dec_col,
   input  logic [K-2:0]          best_state,
   output logic                  out_valid,
   output logic                  out_bit
);
   localparam int NS      = 1 << (K - 1);
   localparam int LATENCY = TB_DEPTH + K - 2;
   localparam int CNT_MAX = LATENCY + 1;
   localparam int CW      = $clog2(CNT_MAX + 1);

   logic [NS-1:0] col_q [TB_DEPTH];
   logic [CW-1:0] cnt_q;
   logic          req_q;
   logic [K-2:0]  walk;
   logic          walk_bit;

   generate
      if (TB_DEPTH < K) begin : g_bad_depth
         $error("vit_traceback: TB_DEPTH must be at least K");
      end
   endgenerate

   // walk back from the best state through every stored column
   always_comb begin
      walk = best_state;
      for (int k = 0; k < TB_DEPTH; k++) walk = {walk[K-3:0], col_q[k][walk]};
      walk_bit = walk[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < TB_DEPTH; k++) col_q[k] <= '0;
         cnt_q     <= '0;
         req_q     <= 1'b0;
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         req_q     <= sym_valid;
         out_valid <= req_q && (cnt_q == CW'(CNT_MAX));
         if (req_q) out_bit <= walk_bit;
         if (sym_valid) begin
            col_q[0] <= dec_col;
            for (int k = 1; k < TB_DEPTH; k++) col_q[k] <= col_q[k-1];
            if (cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> cnt_q == CW'(CNT_MAX)); // R1
   AST_OUT_AFTER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sym_valid, 2)); // R2
   AST_STORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid |=> $stable(col_q[0]) && $stable(cnt_q)); // R5
endmodule

// File: rtl/vit_decoder_core.sv
module vit_decoder_core #(
   parameter int          K          = 7,
   parameter int          SOFT_W     = 3,
   parameter int          PM_W       = 8,
   parameter int          TB_DEPTH   = 5 * K,
   parameter int unsigned GEN_A      = 'o171,
   parameter int unsigned GEN_B      = 'o133,
   parameter int          START_BIAS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SOFT_W-1:0] in_soft_a,
   input  logic [SOFT_W-1:0] in_soft_b,
   output logic              out_valid,
   output logic              out_bit
);
   localparam int BM_W     = SOFT_W + 1;
   localparam int NS       = 1 << (K - 1);
   localparam int BM_MAX   = 2 * ((1 << SOFT_W) - 1);
   localparam int PM_BOUND = START_BIAS + (K + 1) * BM_MAX;

   generate
      if (K < 3 || K > 9) begin : g_bad_k
         $error("vit_decoder_core: K must lie in 3..9");
      end
      if (PM_BOUND >= (1 << PM_W)) begin : g_bad_pm
         $error("vit_decoder_core: PM_W too narrow for the metric spread");
      end
      if (GEN_A >= (1 << K) || GEN_B >= (1 << K)) begin : g_bad_gen
         $error("vit_decoder_core: generator wider than K");
      end
   endgenerate

   logic [BM_W-1:0] bm [vit_pkg::VIT_PAIRS];
   logic [NS-1:0]   dec_col;
   logic [K-2:0]    best_state;

   vit_bmu #(.SOFT_W(SOFT_W), .BM_W(BM_W)) u_bmu (
      .soft_a(in_soft_a),
      .soft_b(in_soft_b),
      .bm    (bm)
   );

   vit_pm_array #(
      .K(K), .PM_W(PM_W), .BM_W(BM_W),
      .GEN_A(GEN_A), .GEN_B(GEN_B), .START_BIAS(START_BIAS)
   ) u_pm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_valid (in_valid),
      .bm        (bm),
      .dec_col   (dec_col),
      .best_state(best_state)
   );

   vit_traceback #(.K(K), .TB_DEPTH(TB_DEPTH)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .sym_valid (in_valid),
      .dec_col   (dec_col),
      .best_state(best_state),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );
endmodule

// File: tb/vit_decoder_core_tb.sv
module vit_decoder_core_tb_top;
   localparam int K      = 7;
   localparam int SOFT_W = 3;
   localparam int DEPTH  = 35;
   localparam int LAT    = DEPTH + K - 2;
   localparam int MAXSYM = 4096;
   localparam logic [K-1:0] GA = 7'o171;
   localparam logic [K-1:0] GB = 7'o133;

   // {symbols, error period (0 = none), error level, idle cycles after each symbol}
   localparam int NCASE = 6;
   localparam logic [31:0] CASES [NCASE] = '{
      {16'd300,  8'd0,  4'd0, 4'd0},
      {16'd300,  8'd0,  4'd0, 4'd2},
      {16'd600,  8'd40, 4'd7, 4'd0},
      {16'd600,  8'd30, 4'd5, 4'd1},
      {16'd4000, 8'd50, 4'd7, 4'd0},
      {16'd400,  8'd0,  4'd0, 4'd3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SOFT_W-1:0] in_soft_a = '0;
   logic [SOFT_W-1:0] in_soft_b = '0;
   logic out_valid, out_bit;

   int checks = 0;
   int errors = 0;
   int unsigned rng = 32'h1234_5678;
   logic src_bits [MAXSYM];
   int rx_cnt, bad_cnt, first_bad;
   logic first_act, first_exp;

   always #10 clk = ~clk;

   vit_decoder_core dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_soft_a(in_soft_a), .in_soft_b(in_soft_b),
      .out_valid(out_valid), .out_bit(out_bit)
   );

   function automatic int unsigned next_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   function automatic string case_tag(input int idx);
      case (idx)
         0: return "R3 R6";
         1: return "R3 R5";
         2: return "R4 R8";
         3: return "R4 R5";
         4: return "R7";
         default: return "R5 R6";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic collect(input int n_sym);
      if (out_valid === 1'b1) begin
         if (rx_cnt < n_sym && out_bit !== src_bits[rx_cnt]) begin
            if (bad_cnt == 0) begin
               first_bad = rx_cnt;
               first_act = out_bit;
               first_exp = src_bits[rx_cnt];
            end
            bad_cnt++;
         end
         rx_cnt++;
      end
   endtask

   task automatic run_case(input int idx);
      int n_sym, per, lvl, gap;
      logic [K-2:0] enc;
      logic [K-1:0] win;
      logic u, ca, cb;
      n_sym = int'(CASES[idx][31:16]);
      per   = int'(CASES[idx][15:8]);
      lvl   = int'(CASES[idx][7:4]);
      gap   = int'(CASES[idx][3:0]);
      rx_cnt = 0; bad_cnt = 0; first_bad = 0; first_act = 0; first_exp = 0;
      enc = '0;
      do_reset();
      check(out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);
      for (int i = 0; i < n_sym; i++) begin
         u = next_rand() & 1;
         src_bits[i] = u;
         win = {u, enc};
         ca = ^(win & GA);
         cb = ^(win & GB);
         enc = {u, enc[K-2:1]};
         in_soft_a = ca ? 3'd7 : 3'd0;
         in_soft_b = cb ? 3'd7 : 3'd0;
         if (per > 0 && (i % per) == per / 2) begin
            if ((i / per) % 2 == 0) in_soft_a = ca ? 3'(7 - lvl) : 3'(lvl);
            else                    in_soft_b = cb ? 3'(7 - lvl) : 3'(lvl);
         end
         in_valid = 1'b1;
         @(negedge clk);
         collect(n_sym);
         for (int g = 0; g < gap; g++) begin
            in_valid  = 1'b0;
            in_soft_a = 3'(next_rand());
            in_soft_b = 3'(next_rand());
            @(negedge clk);
            collect(n_sym);
         end
      end
      in_valid = 1'b0;
      repeat (4) begin
         @(negedge clk);
         collect(n_sym);
      end
      check(rx_cnt == n_sym - LAT, {"R2 output count, ", case_tag(idx)}, rx_cnt, n_sym - LAT);
      check(bad_cnt == 0, {case_tag(idx), " decoded bit mismatches"}, bad_cnt, 0);
      if (bad_cnt != 0)
         $display("  first mismatch at bit %0d: actual=%0d expected=%0d",
                  first_bad, first_act, first_exp);
   endtask

   // R1/R2: exact hold-off and pulse position, symbols separated by idle cycles
   task automatic latency_test();
      do_reset();
      for (int i = 0; i < LAT + 3; i++) begin
         in_valid = 1'b1; in_soft_a = 3'd0; in_soft_b = 3'd0;
         @(negedge clk);
         check(out_valid == 1'b0, "R2 no pulse on accept edge", int'(out_valid), 0);
         in_valid = 1'b0; in_soft_a = 3'd7; in_soft_b = 3'd7;
         @(negedge clk);
         check(out_valid == (i >= LAT), "R1 first pulse after symbol L", int'(out_valid), int'(i >= LAT));
         if (out_valid)
            check(out_bit == 1'b0, "R3 all-zero stream", int'(out_bit), 0);
         @(negedge clk);
         check(out_valid == 1'b0, "R2 single-cycle pulse", int'(out_valid), 0);
      end
      // reset in mid-stream clears the output
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 hold-off restarts after reset", int'(out_valid), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      latency_test();
      for (int c = 0; c < NCASE; c++) run_case(c);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule